// File: doc/BRIEF.md
# Averaging Conversion Sequencer

This block is the digital control engine for a slow auxiliary successive-approximation converter. It turns the system clock into a slower conversion clock by a power-of-two divisor. It then runs a fixed twelve-step conversion cycle: one step samples the input, ten steps make the bit decisions, and one step loads the result. The block repeats this cycle a programmable number of times and delivers the mean of the conversions as a 10-bit result.

The comparator and the capacitor DAC lie outside this block. The block drives its current trial word on `dac_o`. It takes one comparator decision per bit step on `cmp_i`, where a high level means the analog input is at least the trial value. A single-cycle `start_i` pulse launches a run while the block is idle. `busy_o` covers the whole run. `done_o` pulses for one system clock when `result_o` takes its new value.

Top module: `avg_conv_seq`

## Requirements
- R1: A single conversion takes exactly 12 conversion-clock edges. With both codes at 0, `busy_o` is high for exactly 12 system clocks after the start is accepted.
- R2: Divider code d on `div_code_i` (0 to 7) makes one conversion-clock edge every 2^d system clocks. A run therefore lasts 12 × N × 2^d system clocks, where N is the number of averages.
- R3: Averaging code a on `avg_code_i` gives N = 2^a conversions for a from 0 to 5. Codes 6 and 7 both give N = 32.
- R4: `busy_o` rises in the cycle after an accepted start and falls right after the last load edge. `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low. `result_o` holds its new value in that same cycle.
- R5: Bits are resolved MSB first. In the cycle after the sample edge, `dac_o` equals 10'h200, with only bit 9 set. Each bit edge keeps the trial bit when `cmp_i` is 1 and clears it when `cmp_i` is 0, then sets the next lower bit.
- R6: `result_o` is the sum of the N conversion results shifted right by log2 N. Thirty-two results of 1023 give 1023, with no overflow.
- R7: While `busy_o` is high, a start pulse has no effect, and so do changes on `avg_code_i` and `div_code_i`. Both codes are captured when the start is accepted.
- R8: During reset, and after a reset that hits a running conversion, `busy_o`, `done_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| avg_code_i | input | 3 | Averaging code, 2^code conversions, saturating at 32 |
| div_code_i | input | 3 | Divider code, conversion clock = clk / 2^code |
| cmp_i | input | 1 | Comparator decision, 1 means input ≥ `dac_o` |
| dac_o | output | 10 | Current trial word for the DAC |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when the result updates |
| result_o | output | 10 | Averaged conversion result |

## Verification
Cycle 0 is the first cycle after the edge that accepts a start. `busy_o` must be high from cycle 0 through cycle 12·N·2^d − 1. The MSB-only trial word appears in cycle 2^d, the cycle after the first conversion-clock edge. `done_o` and the new `result_o` are due in cycle 12·N·2^d, and `done_o` must be low again one cycle later. The bench drives inputs and samples outputs on falling edges. It counts those edges from the accepting edge and checks each output only in the cycle where it is due. A stray start and altered codes are applied halfway through every run, to show that they change neither the timing nor the result.

// File: rtl/avg_conv_pkg.sv
package avg_conv_pkg;

  // Saturate an averaging code to the largest supported shift.
  function automatic int avg_shift(input int code, input int max_sh);
    return (code > max_sh) ? max_sh : code;
  endfunction

  // Terminal count for a power-of-two period: 2^sh - 1.
  function automatic int unsigned pow2_minus1(input int unsigned sh);
    return (32'd1 << sh) - 32'd1;
  endfunction

endpackage

// File: rtl/conv_clk_div.sv
module conv_clk_div
  import avg_conv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] div_sh_i,
  output logic              tick_o
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term   = CNT_W'(pow2_minus1(32'(div_sh_i)));
  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R2
  div_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= term));

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             conv_end_o
);
  localparam int LAST_STEP = RES_W + 1;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  trial_q, trial_d;
  logic              sample_edge, bit_edge;
  int                bpos;

  function automatic logic [RES_W-1:0] sar_decide(input logic [RES_W-1:0] t,
                                                  input int b, input logic c);
    logic [RES_W-1:0] r;
    r = t;
    for (int i = 0; i < RES_W; i++) begin
      if (i == b)     r[i] = c;
      if (i == b - 1) r[i] = 1'b1;
    end
    return r;
  endfunction

  assign sample_edge = tick_i && (step_q == '0);
  assign conv_end_o  = tick_i && (step_q == STEP_W'(LAST_STEP));
  assign bit_edge    = tick_i && !sample_edge && !conv_end_o;

  always_comb begin
    bpos    = RES_W - int'(step_q);
    trial_d = trial_q;
    if (sample_edge)   trial_d = MSB_ONLY;
    else if (bit_edge) trial_d = sar_decide(trial_q, bpos, cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      trial_q <= '0;
    end else begin
      trial_q <= trial_d;
      if (clear_i)     step_q <= '0;
      else if (tick_i) step_q <= conv_end_o ? '0 : step_q + 1'b1;
    end
  end

  assign trial_o = trial_q;

  // R1
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(LAST_STEP));

  // R5
  msb_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_edge |=> (trial_q == MSB_ONLY));

endmodule

// File: rtl/avg_accum.sv
module avg_accum
  import avg_conv_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int SH_MAX = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              conv_end_i,
  input  logic [RES_W-1:0]  sample_i,
  input  logic [CODE_W-1:0] avg_sh_i,
  output logic              last_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  localparam int ACC_W = RES_W + SH_MAX;
  localparam int CNT_W = SH_MAX;

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [CNT_W-1:0] cnt_q, n_m1;

  function automatic logic [RES_W-1:0] scale_down(input logic [ACC_W-1:0] s,
                                                  input logic [CODE_W-1:0] sh);
    return RES_W'(s >> sh);
  endfunction

  assign n_m1    = CNT_W'(pow2_minus1(32'(avg_sh_i)));
  assign acc_sum = acc_q + ACC_W'(sample_i);
  assign last_o  = conv_end_i && (cnt_q == n_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last_o;
      if (clear_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (conv_end_i) begin
        if (last_o) begin
          acc_q    <= '0;
          cnt_q    <= '0;
          result_o <= scale_down(acc_sum, avg_sh_i);
        end else begin
          acc_q <= acc_sum;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  avg_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= n_m1);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end_i |-> (acc_sum >= acc_q));

endmodule

// File: rtl/avg_conv_seq.sv
module avg_conv_seq
  import avg_conv_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int CODE_W     = 3,
  parameter int AVG_SH_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] avg_code_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  logic              busy_q;
  logic [CODE_W-1:0] avg_sh_q, div_sh_q;
  logic              start_accept, conv_tick, conv_end, conv_last;

  assign start_accept = start_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      avg_sh_q <= '0;
      div_sh_q <= '0;
    end else if (start_accept) begin
      busy_q   <= 1'b1;
      avg_sh_q <= CODE_W'(avg_shift(32'(avg_code_i), AVG_SH_MAX));
      div_sh_q <= div_code_i;
    end else if (conv_last) begin
      busy_q <= 1'b0;
    end
  end

  conv_clk_div #(.CODE_W(CODE_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run_i(busy_q), .clear_i(start_accept),
    .div_sh_i(div_sh_q), .tick_o(conv_tick)
  );

  sar_engine #(.RES_W(RES_W)) sar_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_accept), .tick_i(conv_tick),
    .cmp_i(cmp_i), .trial_o(dac_o), .conv_end_o(conv_end)
  );

  avg_accum #(.RES_W(RES_W), .SH_MAX(AVG_SH_MAX), .CODE_W(CODE_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_accept), .conv_end_i(conv_end),
    .sample_i(dac_o), .avg_sh_i(avg_sh_q), .last_o(conv_last),
    .done_o(done_o), .result_o(result_o)
  );

  assign busy_o = busy_q;

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_i) |=> busy_q);

  // R4
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_o);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_last) |=> busy_q);

  // R7
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || ($stable(avg_sh_q) && $stable(div_sh_q))));

endmodule

// File: tb/avg_conv_seq_tb_top.sv
module avg_conv_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] avg_code = 3'd0;
  logic [2:0] div_code = 3'd0;
  logic       cmp;
  logic [9:0] dac, result;
  logic       busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int busy_cnt = 0;
  int base_v = 0;
  int step_v = 0;
  int div_v = 1;
  int cur_vin;

  always #5 clk = ~clk;

  // Analog model: input value of conversion j is base + j*step.
  always @(posedge clk) busy_cnt <= busy ? busy_cnt + 1 : 0;
  always_comb cur_vin = base_v + (busy_cnt / (12 * div_v)) * step_v;
  assign cmp = (cur_vin >= int'(dac));

  avg_conv_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .avg_code_i(avg_code),
    .div_code_i(div_code), .cmp_i(cmp), .dac_o(dac), .busy_o(busy),
    .done_o(done), .result_o(result)
  );

  // {avg code, div code, base value, step per conversion}
  localparam logic [25:0] VEC [12] = '{
    {3'd0, 3'd0, 10'd341,  10'd0},
    {3'd0, 3'd3, 10'd1023, 10'd0},
    {3'd0, 3'd0, 10'd0,    10'd0},
    {3'd1, 3'd1, 10'd100,  10'd3},
    {3'd2, 3'd0, 10'd500,  10'd7},
    {3'd3, 3'd2, 10'd10,   10'd100},
    {3'd5, 3'd0, 10'd1023, 10'd0},
    {3'd6, 3'd0, 10'd200,  10'd5},
    {3'd7, 3'd1, 10'd7,    10'd31},
    {3'd4, 3'd7, 10'd300,  10'd1},
    {3'd0, 3'd7, 10'd777,  10'd0},
    {3'd3, 3'd5, 10'd640,  10'd9}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int a, input int d, input int base, input int step);
    int n, dv, lat, sum, exp;
    bit busy_ok;
    n = (a > 5) ? 32 : (1 << a);
    dv = 1 << d;
    lat = 12 * n * dv;
    sum = 0;
    busy_ok = 1'b1;
    for (int j = 0; j < n; j++) sum += base + j * step;
    exp = sum / n;
    @(negedge clk);
    avg_code = 3'(a); div_code = 3'(d);
    base_v = base; step_v = step; div_v = dv;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    avg_code = 3'(~a);
    div_code = 3'(7 - d);
    for (int i = 0; i <= lat + 1; i++) begin
      if (i > 0) @(negedge clk);
      if (i < lat && busy !== 1'b1) busy_ok = 1'b0;
      if (i == dv) check("R5 MSB-only trial word", int'(dac), 512);
      if (i == lat / 2) start = 1'b1;          // R7 stray start while busy
      if (i == lat / 2 + 1) start = 1'b0;
      if (i == lat) begin
        check("R4 busy low at end", int'(busy), 0);
        check("R2 R3 done at 12*N*D", int'(done), 1);
        check("R6 averaged result", int'(result), exp);
      end
      if (i == lat + 1) check("R4 done single cycle", int'(done), 0);
    end
    check("R1 R2 R7 busy held for whole run", int'(busy_ok), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 busy in reset", int'(busy), 0);
    check("R8 done in reset", int'(done), 0);
    check("R8 result in reset", int'(result), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++)
      run_case(int'(VEC[k][25:23]), int'(VEC[k][22:20]),
               int'(VEC[k][19:10]), int'(VEC[k][9:0]));

    // R8: reset hitting a running conversion
    @(negedge clk);
    avg_code = 3'd2; div_code = 3'd1; base_v = 50; step_v = 0; div_v = 2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 busy after mid-run reset", int'(busy), 0);
    check("R8 done after mid-run reset", int'(done), 0);
    check("R8 result after mid-run reset", int'(result), 0);
    rst_n = 1'b1;
    run_case(0, 0, 612, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule